// File: doc/BRIEF.md
# I2C Slave Dual-Slot Address Matcher

This block runs the address phase of an I2C target. It takes SCL and SDA samples that are already synchronised to the system clock and detects START and STOP conditions. After a START it shifts in the address byte, or two bytes when the target uses 10-bit addressing. It then compares what it received against two programmable address slots.

Slot one holds a 10-bit value. It can be compared as a 7-bit address with a per-bit ignore mask, or as a full 10-bit address. Slot two is always 7 bits wide, and a 3-bit code sets how many of its low bits are ignored.

On a match the block does four things:
- it pulls SDA low for the acknowledge pulse;
- it raises a sticky match flag and an optional interrupt;
- it latches the 7 received address bits;
- one cycle later, it reports whether the controller asked to read or to write.

Software clears the flag with a one-cycle clear pulse. When nothing matches, the block stays silent until the next START or STOP.

The controller is a five-state machine:
- **IDLE** waits for START.
- **HDR** shifts in the first byte.
- **ACK_HDR** acknowledges a 10-bit header.
- **LOW** shifts in the second 10-bit byte.
- **ACK_FIN** acknowledges a completed match.

Its transitions are:
- START from any state goes to HDR, and STOP from any state goes to IDLE.
- From HDR, at the SCL fall that ends bit 8: a 7-bit hit goes to ACK_FIN; otherwise a header hit goes to ACK_HDR; otherwise the machine goes to IDLE.
- ACK_HDR goes to LOW at the SCL fall that ends the ninth pulse.
- From LOW, at the SCL fall that ends bit 8: a low-byte hit goes to ACK_FIN; otherwise the machine goes to IDLE.
- ACK_FIN goes to IDLE at the SCL fall that ends the ninth pulse.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, match_flag, irq, rx_addr, dir_tx and sda_pull are all 0.
- R2: A START (SDA falling while SCL is high) begins a new address phase from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the block to idle, and idle ignores SCL pulses until the next START.
- R3: With slot one enabled and in 7-bit mode, received byte bits 7:1 are compared with a1_addr bits 7:1. A set bit i of a1_mask excludes address bit i+1 from the comparison. Byte bit 0 is the R/W bit.
- R4: Slot two compares byte bits 7:1 with a2_addr[6:0]. The mask code a2_mcode works as follows: code 0 ignores no bits; a code k from 1 to 6 ignores the lowest k bits of a2_addr; code 7 ignores all 7 bits, so any address matches.
- R5: A disabled slot never matches. A byte that matches either enabled slot is a match. With both slots disabled, the block neither acknowledges nor flags.
- R6: With slot one in 10-bit mode, the first byte must be 11110, then a1_addr[9:8], then the R/W bit. Such a byte is acknowledged without raising the flag, and it never takes part in the 7-bit comparison. The second byte must equal a1_addr[7:0] exactly, and neither mask applies to it. If the second byte differs, the block does not acknowledge it and does not raise the flag.
- R7: On a match, match_flag is set. rx_addr takes the first received byte's bits 7:1 (the header bits in 10-bit mode). irq is 1 exactly while match_flag and irq_en are both 1.
- R8: dir_tx takes the matched transaction's R/W bit (1 = controller reads) one cycle after match_flag rises, never earlier.
- R9: sda_pull is 1 from the cycle after the SCL fall that ends bit 8 until the cycle after the SCL fall that ends the ninth pulse, and only for a matched or header byte. After a byte that does not match, later bytes are ignored until START or STOP.
- R10: match_flag stays set until a flag_clr pulse. If a match and a clear happen in the same cycle, the match wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| a1_en | input | 1 | Slot one enable |
| a1_ten | input | 1 | Slot one 10-bit mode select |
| a1_addr | input | 10 | Slot one address |
| a1_mask | input | 7 | Slot one ignore mask for address bits 7:1 |
| a2_en | input | 1 | Slot two enable |
| a2_addr | input | 7 | Slot two 7-bit address |
| a2_mcode | input | 3 | Slot two mask code |
| irq_en | input | 1 | Match interrupt enable |
| flag_clr | input | 1 | One-cycle clear of match_flag |
| match_flag | output | 1 | Sticky address-match flag |
| irq | output | 1 | Match interrupt |
| rx_addr | output | 7 | Latched received address bits 7:1 |
| dir_tx | output | 1 | 1 when the target must transmit (read) |
| sda_pull | output | 1 | 1 to drive SDA low (acknowledge) |

## Verification
The assertions check several rules on every cycle:
- sda_pull only changes while SCL is low;
- dir_tx never moves unless match_flag was already set;
- the flag holds until it is cleared;
- irq implies the flag;
- rx_addr moves only together with a set flag;
- no acknowledge starts while both slots are disabled.

Only the bench scenarios can show that the comparisons themselves are right: the per-bit mask, each mask code, the 10-bit header and low byte, and slot priority. The same holds for the effects of repeated START and aborting STOP, and for the silence after a byte that does not match.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W = 8;
    localparam int A7_W   = 7;
    localparam int A10_W  = 10;
    localparam int MC_W   = 3;
    localparam int BIT_CW = $clog2(BYTE_W + 2);

    localparam logic [BIT_CW-1:0] CNT_BYTE = BIT_CW'(BYTE_W);
    localparam logic [BIT_CW-1:0] CNT_ACK  = BIT_CW'(BYTE_W + 1);

    localparam logic [4:0] HDR10_TAG = 5'b11110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_ACK_HDR,
        S_LOW,
        S_ACK_FIN
    } am_state_e;

endpackage

// File: rtl/i2c_am_edges.sv
module i2c_am_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Bus idles high, so both history bits reset to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = !scl_q && scl_i;
    assign scl_fall  = scl_q && !scl_i;
    assign start_det = scl_q && scl_i && sda_q && !sda_i;
    assign stop_det  = scl_q && scl_i && !sda_q && sda_i;

endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              a1_en,
    input  logic              a1_ten,
    input  logic [A10_W-1:0]  a1_addr,
    input  logic [A7_W-1:0]   a1_mask,
    input  logic              a2_en,
    input  logic [A7_W-1:0]   a2_addr,
    input  logic [MC_W-1:0]   a2_mcode,
    output logic              hit7,
    output logic              hdr_hit,
    output logic              low_hit
);
    logic [A7_W-1:0] a2_mask;
    logic [A7_W-1:0] rx7;
    logic            hit1;
    logic            hit2;

    assign rx7 = rx_byte[BYTE_W-1:1];

    // Mask code k ignores the k lowest bits of the 7-bit address.
    for (genvar g = 0; g < A7_W; g++) begin : g_mcode
        assign a2_mask[g] = (a2_mcode > MC_W'(g));
    end

    assign hit1 = a1_en && !a1_ten &&
                  (((rx7 ^ a1_addr[A7_W:1]) & ~a1_mask) == '0);
    assign hit2 = a2_en && (((rx7 ^ a2_addr) & ~a2_mask) == '0);
    assign hit7 = hit1 || hit2;

    assign hdr_hit = a1_en && a1_ten &&
                     (rx_byte[BYTE_W-1:3] == HDR10_TAG) &&
                     (rx_byte[2:1] == a1_addr[A10_W-1:BYTE_W]);
    assign low_hit = a1_en && a1_ten && (rx_byte == a1_addr[BYTE_W-1:0]);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             a1_en,
    input  logic             a1_ten,
    input  logic [A10_W-1:0] a1_addr,
    input  logic [A7_W-1:0]  a1_mask,
    input  logic             a2_en,
    input  logic [A7_W-1:0]  a2_addr,
    input  logic [MC_W-1:0]  a2_mcode,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             match_flag,
    output logic             irq,
    output logic [A7_W-1:0]  rx_addr,
    output logic             dir_tx,
    output logic             sda_pull
);
    am_state_e         state, state_nx;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              hit7, hdr_hit, low_hit;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] hdr_q;
    logic              flag_q;
    logic [A7_W-1:0]   rx_q;
    logic              dir_q, dir_pend, dir_val;
    logic              byte_done, ack_done, match_set, in_ack;

    i2c_am_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_am_cmp u_cmp (
        .rx_byte  (shreg),
        .a1_en    (a1_en),
        .a1_ten   (a1_ten),
        .a1_addr  (a1_addr),
        .a1_mask  (a1_mask),
        .a2_en    (a2_en),
        .a2_addr  (a2_addr),
        .a2_mcode (a2_mcode),
        .hit7     (hit7),
        .hdr_hit  (hdr_hit),
        .low_hit  (low_hit)
    );

    assign byte_done = scl_fall && (bit_cnt == CNT_BYTE);
    assign ack_done  = scl_fall && (bit_cnt == CNT_ACK);
    assign in_ack    = (state == S_ACK_HDR) || (state == S_ACK_FIN);
    assign match_set = byte_done &&
                       (((state == S_HDR) && hit7) || ((state == S_LOW) && low_hit));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    state_nx = S_IDLE;
            S_HDR: begin
                if (byte_done) begin
                    if (hit7)         state_nx = S_ACK_FIN;
                    else if (hdr_hit) state_nx = S_ACK_HDR;
                    else              state_nx = S_IDLE;
                end
            end
            S_ACK_HDR: if (ack_done) state_nx = S_LOW;
            S_LOW: begin
                if (byte_done) state_nx = low_hit ? S_ACK_FIN : S_IDLE;
            end
            S_ACK_FIN: if (ack_done) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
        if (start_det)     state_nx = S_HDR;
        else if (stop_det) state_nx = S_IDLE;
    end

    // Shift path, flag, captured address and direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            hdr_q    <= '0;
            flag_q   <= 1'b0;
            rx_q     <= '0;
            dir_q    <= 1'b0;
            dir_pend <= 1'b0;
            dir_val  <= 1'b0;
        end else begin
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else if (ack_done && in_ack) begin
                bit_cnt <= '0;
            end else if (scl_rise && (state != S_IDLE)) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt < CNT_BYTE) shreg <= {shreg[BYTE_W-2:0], sda_i};
            end

            if (byte_done && (state == S_HDR) && !hit7 && hdr_hit) hdr_q <= shreg;

            if (match_set)     flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;

            dir_pend <= match_set;
            if (match_set) begin
                rx_q    <= (state == S_HDR) ? shreg[BYTE_W-1:1] : hdr_q[BYTE_W-1:1];
                dir_val <= (state == S_HDR) ? shreg[0] : hdr_q[0];
            end
            if (dir_pend) dir_q <= dir_val;
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            S_ACK_HDR, S_ACK_FIN: sda_pull = 1'b1;
            default:              sda_pull = 1'b0;
        endcase
        match_flag = flag_q;
        irq        = flag_q && irq_en;
        rx_addr    = rx_q;
        dir_tx     = dir_q;
    end

endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk
    import i2c_am_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            scl_i,
    input logic            a1_en,
    input logic            a2_en,
    input logic            flag_clr,
    input logic            match_flag,
    input logic            irq,
    input logic [A7_W-1:0] rx_addr,
    input logic            dir_tx,
    input logic            sda_pull
);
    a_r9_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_i);

    a_r8_dir_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_tx != $past(dir_tx)) |-> $past(match_flag));

    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(match_flag) && !$past(flag_clr)) |-> match_flag);

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> match_flag);

    a_r7_rx_moves_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_addr != $past(rx_addr)) |-> match_flag);

    a_r5_no_slot_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(a1_en || a2_en));

endmodule

bind i2c_addr_match i2c_am_chk u_am_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .a1_en      (a1_en),
    .a2_en      (a2_en),
    .flag_clr   (flag_clr),
    .match_flag (match_flag),
    .irq        (irq),
    .rx_addr    (rx_addr),
    .dir_tx     (dir_tx),
    .sda_pull   (sda_pull)
);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl, sda;
    logic       a1_en, a1_ten, a2_en, irq_en, flag_clr;
    logic [9:0] a1_addr;
    logic [6:0] a1_mask, a2_addr;
    logic [2:0] a2_mcode;
    logic       match_flag, irq, dir_tx, sda_pull;
    logic [6:0] rx_addr;

    int n_cmp = 0;
    int n_bad = 0;
    logic g_lo, g_hi, g_flag_a, g_dir_a, g_dir_b;

    always #5 clk = ~clk;

    i2c_addr_match i_i2c_addr_match (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .a1_en(a1_en), .a1_ten(a1_ten), .a1_addr(a1_addr), .a1_mask(a1_mask),
        .a2_en(a2_en), .a2_addr(a2_addr), .a2_mcode(a2_mcode),
        .irq_en(irq_en), .flag_clr(flag_clr),
        .match_flag(match_flag), .irq(irq), .rx_addr(rx_addr),
        .dir_tx(dir_tx), .sda_pull(sda_pull)
    );

    typedef struct packed {
        logic       a1e;
        logic       a1t;
        logic [9:0] a1a;
        logic [6:0] a1m;
        logic       a2e;
        logic [6:0] a2a;
        logic [2:0] a2c;
        logic [7:0] byt;
        logic       ack;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 10'h0A4, 7'h00, 1'b0, 7'h00, 3'd0, 8'hA4, 1'b1, 4'd3}, // R3 exact
        '{1'b1, 1'b0, 10'h0A4, 7'h00, 1'b0, 7'h00, 3'd0, 8'hA6, 1'b0, 4'd3}, // R3 miss
        '{1'b1, 1'b0, 10'h0A4, 7'h01, 1'b0, 7'h00, 3'd0, 8'hA7, 1'b1, 4'd3}, // R3 masked bit
        '{1'b0, 1'b0, 10'h0A4, 7'h00, 1'b0, 7'h00, 3'd0, 8'hA4, 1'b0, 4'd5}, // R5 disabled
        '{1'b0, 1'b0, 10'h000, 7'h00, 1'b1, 7'h3C, 3'd0, 8'h79, 1'b1, 4'd4}, // R4 code 0
        '{1'b0, 1'b0, 10'h000, 7'h00, 1'b1, 7'h3C, 3'd2, 8'h7E, 1'b1, 4'd4}, // R4 code 2 hit
        '{1'b0, 1'b0, 10'h000, 7'h00, 1'b1, 7'h3C, 3'd2, 8'h70, 1'b0, 4'd4}, // R4 code 2 miss
        '{1'b0, 1'b0, 10'h000, 7'h00, 1'b1, 7'h3C, 3'd7, 8'h01, 1'b1, 4'd4}, // R4 code 7 all
        '{1'b0, 1'b0, 10'h000, 7'h00, 1'b1, 7'h3C, 3'd6, 8'h80, 1'b0, 4'd4}, // R4 code 6 miss
        '{1'b0, 1'b0, 10'h000, 7'h00, 1'b1, 7'h3C, 3'd6, 8'h02, 1'b1, 4'd4}, // R4 code 6 hit
        '{1'b0, 1'b0, 10'h000, 7'h00, 1'b0, 7'h3C, 3'd7, 8'h01, 1'b0, 4'd5}, // R5 slot two off
        '{1'b1, 1'b1, 10'h0A4, 7'h00, 1'b0, 7'h00, 3'd0, 8'hA4, 1'b0, 4'd6}, // R6 no 7-bit in 10-bit mode
        '{1'b1, 1'b0, 10'h0A4, 7'h00, 1'b1, 7'h3C, 3'd0, 8'h78, 1'b1, 4'd5}  // R5 either slot
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; half(); scl = 1'b1; half();
        sda = 1'b0; half(); scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda = 1'b0; half(); scl = 1'b1; half(); sda = 1'b1; half();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda = b[i]; half(); scl = 1'b1; half(); scl = 1'b0; half();
        end
    endtask

    // Eight data bits plus the ninth pulse; records the acknowledge window.
    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 7);
        sda = b[0]; half(); scl = 1'b1; half(); scl = 1'b0;
        @(negedge clk); g_flag_a = match_flag; g_dir_a = dir_tx;
        @(negedge clk); g_dir_b = dir_tx;
        repeat (HALF - 2) @(negedge clk);
        sda = 1'b1; half();
        g_lo = sda_pull;
        scl = 1'b1; half();
        g_hi = sda_pull;
        scl = 1'b0; half();
        chk("R9 pull released after ninth pulse", sda_pull, 1'b0);
    endtask

    task automatic clr_pulse();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
    endtask

    task automatic cfg_slot1(input logic ten, input logic [9:0] a, input logic [6:0] m);
        a1_en = 1'b1; a1_ten = ten; a1_addr = a; a1_mask = m; a2_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
        a1_en = 0; a1_ten = 0; a1_addr = '0; a1_mask = '0;
        a2_en = 0; a2_addr = '0; a2_mcode = '0; irq_en = 0; flag_clr = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag", match_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx_addr", rx_addr, 0);
        chk("R1 dir", dir_tx, 0);
        chk("R1 pull", sda_pull, 0);

        for (int k = 0; k < NV; k++) begin
            a1_en = VECS[k].a1e; a1_ten = VECS[k].a1t; a1_addr = VECS[k].a1a;
            a1_mask = VECS[k].a1m; a2_en = VECS[k].a2e; a2_addr = VECS[k].a2a;
            a2_mcode = VECS[k].a2c;
            clr_pulse();
            bus_start();
            send_byte(VECS[k].byt);
            bus_stop();
            n_cmp++;
            if ({g_lo, g_hi, match_flag} !== {3{VECS[k].ack}}) begin
                n_bad++;
                $display("FAIL R%0d vector %0d ack/flag actual=%b%b%b expected=%b",
                         VECS[k].req, k, g_lo, g_hi, match_flag, VECS[k].ack);
            end
            if (VECS[k].ack) begin
                chk("R7 rx_addr from vector", rx_addr, VECS[k].byt[7:1]);
                chk("R8 dir from vector", dir_tx, VECS[k].byt[0]);
            end
        end

        // R6: 10-bit write, header 11110_10_0 then low byte B5
        cfg_slot1(1'b1, 10'h2B5, 7'h00);
        clr_pulse();
        bus_start();
        send_byte(8'hF4);
        chk("R6 header acked", g_hi, 1);
        chk("R6 no flag on header", match_flag, 0);
        send_byte(8'hB5);
        chk("R6 low byte acked", g_hi, 1);
        bus_stop();
        chk("R7 flag after 10-bit", match_flag, 1);
        chk("R7 rx_addr header bits", rx_addr, 7'h7A);
        chk("R8 dir write", dir_tx, 0);

        // R6: wrong low byte, full mask must not help
        cfg_slot1(1'b1, 10'h2B5, 7'h7F);
        clr_pulse();
        bus_start();
        send_byte(8'hF4);
        chk("R6 header acked with mask", g_hi, 1);
        send_byte(8'hB4);
        chk("R6 wrong low byte not acked", g_hi, 0);
        bus_stop();
        chk("R6 no flag on wrong low", match_flag, 0);

        // R8: 10-bit read; direction lags the flag by one cycle
        cfg_slot1(1'b1, 10'h2B5, 7'h00);
        clr_pulse();
        bus_start();
        send_byte(8'hF5);
        send_byte(8'hB5);
        chk("R8 flag set at byte end", g_flag_a, 1);
        chk("R8 dir not yet updated", g_dir_a, 0);
        chk("R8 dir updated next cycle", g_dir_b, 1);
        bus_stop();

        // R7 interrupt gating
        irq_en = 1'b1; @(negedge clk);
        chk("R7 irq on", irq, 1);
        irq_en = 1'b0; @(negedge clk);
        chk("R7 irq gated", irq, 0);

        // R10 hold and clear
        repeat (20) @(negedge clk);
        chk("R10 flag holds", match_flag, 1);
        clr_pulse();
        chk("R10 flag cleared", match_flag, 0);

        // R2 repeated START mid-byte
        cfg_slot1(1'b0, 10'h0A4, 7'h00);
        bus_start();
        send_bits(8'hFF, 3);
        bus_start();
        send_byte(8'hA4);
        chk("R2 ack after repeated start", g_hi, 1);
        bus_stop();
        chk("R2 flag after repeated start", match_flag, 1);

        // R2 STOP aborts; bytes without START are ignored
        clr_pulse();
        bus_start();
        send_bits(8'hA4, 3);
        bus_stop();
        send_byte(8'hA4);
        chk("R2 idle ignores byte", g_hi, 0);
        bus_stop();
        chk("R2 no flag after stop", match_flag, 0);

        // R9 after a miss the rest is ignored
        bus_start();
        send_byte(8'hA6);
        chk("R9 miss not acked", g_hi, 0);
        send_byte(8'hA4);
        chk("R9 later byte ignored", g_hi, 0);
        bus_stop();
        chk("R9 no flag after miss", match_flag, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule